// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block takes a wide bank of GPIO pad inputs and routes one pad onto each of eight interrupt channels. Each channel turns its pad into a trigger for a parent interrupt controller that only accepts active-high signals. The trigger can be a level, a single edge, or both edges. For a channel set to level-low or falling-edge sensing, the pad is inverted first. The parent therefore only ever sees a high level or a rising edge, reported as a one-cycle pulse.

Pads first pass through a two-flop synchronizer. Each channel then has a selector, an optional inversion stage and a digital glitch filter whose stability window is set in software. An edge detector comes last. Software sets up the block through a small register bus with read-back. Rewriting a channel's pad selector or trigger mode reloads that channel's filter and edge history from its new input, so the change itself never looks like an interrupt.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset all configuration reads as zero and every irq_out bit is low. This is level-high mode with pad 0 selected and the filter bypassed on every channel.
- R2: The register map uses byte offsets on bus_addr. Offset 0x00 holds the mode register: edge-enable for channel c at bit c, both-edges at bit 8+c, and invert (low/falling) at bit 16+c. Bits 31:24 of that register read as zero. Offset 0x04 holds the pad selectors of channels 0-3 and offset 0x08 those of channels 4-7, with channel c in the byte at bit (c mod 4)*8. Offset 0x0C holds a 4-bit filter value per channel at bit c*4. Other offsets read zero, and writes to them change nothing.
- R3: Each channel follows only the pad whose index is in its selector field. Activity on any other pad has no effect on it.
- R4: In level mode (edge and both-edges bits clear) with filter 0, irq_out follows the selected pad four clock edges after the pad changes. The pad is inverted when the invert bit is set.
- R5: In edge mode, a rising edge of the (possibly inverted) pad gives a single one-cycle high pulse on irq_out. The opposite edge gives nothing. With the invert bit set, this means a falling pad edge pulses.
- R6: With the both-edges bit set, every pad transition in either direction gives a one-cycle pulse, and that channel's edge and invert bits are ignored.
- R7: A nonzero filter value N accepts a new input level only after it has differed from the accepted level for N consecutive clocks. A level-mode output then changes N+3 edges after the pad does. Shorter glitches never reach irq_out.
- R8: Writing a different pad selector or mode to a channel never produces a pulse or edge on that channel's output by itself. A genuine pad edge after the change is still reported.
- R9: Channels operate independently. A pad routed to one channel does not affect a channel that selects a different pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPAD | Asynchronous pad inputs |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 8 | Active-high interrupt per channel |

## Verification
The hardest case to reach from the ports is a configuration change that would produce a false edge without the history reload. That needs the old and new pads at opposite levels, or an invert bit that flips the channel's internal input, at the moment of the write. The stimulus parks two pads at opposite levels and switches the selector between them. It then flips a channel from falling to rising sensing while its pad is held high, and watches the output for a dozen cycles. The filter is probed exactly at its boundary: a glitch one clock shorter than the window is rejected, and a held level appears on the predicted edge.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NPAD = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPAD-1:0] pad_in,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [7:0]      irq_out
);
  localparam int NCH   = 8;
  localparam int SEL_W = 8;
  localparam int FLT_W = 4;
  localparam int NSEL  = 1 << SEL_W;

  logic [NPAD-1:0]  s1, s2;
  logic [NSEL-1:0]  pad_ext;
  logic [NCH-1:0]   edge_en, both_en, low_en;
  logic [SEL_W-1:0] sel  [NCH];
  logic [FLT_W-1:0] filt [NCH];
  logic [FLT_W-1:0] cnt  [NCH];
  logic [NCH-1:0]   raw, flt, prev, seed, chg, irq_q;
  logic             wr;

  assign wr      = bus_valid & bus_write;
  assign irq_out = irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
    end

  always_comb begin
    pad_ext = '0;
    pad_ext[NPAD-1:0] = s2;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_en <= '0;
      both_en <= '0;
      low_en  <= '0;
      for (int c = 0; c < NCH; c++) begin
        sel[c]  <= '0;
        filt[c] <= '0;
      end
    end else if (wr) begin
      case (bus_addr)
        8'h00: begin
          edge_en <= bus_wdata[7:0];
          both_en <= bus_wdata[15:8];
          low_en  <= bus_wdata[23:16];
        end
        8'h04: for (int c = 0; c < 4; c++) sel[c]   <= bus_wdata[c*8 +: 8];
        8'h08: for (int c = 0; c < 4; c++) sel[c+4] <= bus_wdata[c*8 +: 8];
        8'h0C: for (int c = 0; c < NCH; c++) filt[c] <= bus_wdata[c*4 +: 4];
        default: ;
      endcase
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = {8'h00, low_en, both_en, edge_en};
      8'h04: bus_rdata = {sel[3], sel[2], sel[1], sel[0]};
      8'h08: bus_rdata = {sel[7], sel[6], sel[5], sel[4]};
      8'h0C: for (int c = 0; c < NCH; c++) bus_rdata[c*4 +: 4] = filt[c];
      default: bus_rdata = '0;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign chg[c] = wr && (
      (bus_addr == 8'h00 &&
       {bus_wdata[c], bus_wdata[8+c], bus_wdata[16+c]} != {edge_en[c], both_en[c], low_en[c]}) ||
      (bus_addr == ((c < 4) ? 8'h04 : 8'h08) && bus_wdata[(c%4)*8 +: 8] != sel[c]));

    assign raw[c] = pad_ext[sel[c]] ^ (low_en[c] & ~both_en[c]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        flt[c]   <= 1'b0;
        prev[c]  <= 1'b0;
        seed[c]  <= 1'b0;
        irq_q[c] <= 1'b0;
        cnt[c]   <= '0;
      end else begin
        seed[c] <= chg[c];
        if (seed[c]) begin
          flt[c]   <= raw[c];
          prev[c]  <= raw[c];
          cnt[c]   <= '0;
          irq_q[c] <= (edge_en[c] | both_en[c]) ? 1'b0 : raw[c];
        end else begin
          prev[c] <= flt[c];
          if (filt[c] == '0) begin
            flt[c] <= raw[c];
            cnt[c] <= '0;
          end else if (raw[c] == flt[c]) begin
            cnt[c] <= '0;
          end else if (cnt[c] == filt[c] - 1'b1) begin
            flt[c] <= raw[c];
            cnt[c] <= '0;
          end else begin
            cnt[c] <= cnt[c] + 1'b1;
          end
          irq_q[c] <= both_en[c] ? (flt[c] ^ prev[c]) :
                      edge_en[c] ? (flt[c] & ~prev[c]) : flt[c];
        end
      end

    p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[c] && edge_en[c] && !both_en[c]) |=> !irq_q[c]);

    p_seed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seed[c] && (edge_en[c] || both_en[c])) |=> !irq_q[c]);

    p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_en[c] && !both_en[c] && !seed[c]) |=> (irq_q[c] == $past(flt[c])));

    p_filter_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (filt[c] != '0 && !seed[c] && raw[c] == flt[c]) |=> $stable(flt[c]));
  end

  p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(bus_addr inside {8'h00, 8'h04, 8'h08, 8'h0C})) |=>
      ($stable(edge_en) && $stable(both_en) && $stable(low_en)));
endmodule

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] pad_in = '0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [7:0]   irq_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_router #(.NPAD(256)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  // {ch, pad, edge, both, low, v0, v1, rises, final}
  localparam logic [18:0] VEC [11] = '{
    {3'd0, 8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1},
    {3'd1, 8'd200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
    {3'd2, 8'd17,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1},
    {3'd3, 8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {3'd4, 8'd64,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
    {3'd5, 8'd3,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0},
    {3'd6, 8'd128, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0},
    {3'd7, 8'd99,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {3'd0, 8'd42,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0},
    {3'd1, 8'd7,   1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
    {3'd2, 8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic count_rises(int ch, int cycles, output int rises);
    logic last;
    last = irq_out[ch];
    rises = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (irq_out[ch] && !last) rises++;
      last = irq_out[ch];
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [18:0] v;
    int ch, pad, rises;
    string req;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", irq_out, 0);
    rd(8'h00, d); chk("R1 mode", d, 0);
    rd(8'h04, d); chk("R1 sel_lo", d, 0);
    rd(8'h08, d); chk("R1 sel_hi", d, 0);
    rd(8'h0C, d); chk("R1 filt", d, 0);

    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 mode", d, 32'h00FF_FFFF);
    wr(8'h04, 32'h4433_2211); rd(8'h04, d); chk("R2 sel_lo", d, 32'h4433_2211);
    wr(8'h08, 32'h8877_6655); rd(8'h08, d); chk("R2 sel_hi", d, 32'h8877_6655);
    wr(8'h0C, 32'h1234_5678); rd(8'h0C, d); chk("R2 filt", d, 32'h1234_5678);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R2 unmapped read", d, 0);
    rd(8'h0C, d); chk("R2 unmapped write ignored", d, 32'h1234_5678);
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 0);
    repeat (10) @(negedge clk);

    // Vector table: R4 level, R5 edge, R6 both edges
    for (int i = 0; i < 11; i++) begin
      v = VEC[i];
      ch = int'(v[18:16]);
      pad = int'(v[15:8]);
      req = v[6] ? "R6" : (v[7] ? "R5" : "R4");
      @(negedge clk);
      pad_in = '0;
      pad_in[pad] = v[4];
      wr((ch < 4) ? 8'h04 : 8'h08, 32'(pad) << ((ch % 4) * 8));
      wr(8'h00, (32'(v[7]) << ch) | (32'(v[6]) << (8 + ch)) | (32'(v[5]) << (16 + ch)));
      repeat (12) @(negedge clk);
      pad_in[pad] = v[3];
      count_rises(ch, 10, rises);
      chk({req, " rises"}, rises, 32'(v[2:1]));
      chk({req, " final"}, irq_out[ch], v[0]);
    end

    // R3 selection
    wr(8'h00, 0); wr(8'h04, 0);
    wr(8'h08, 32'h0000_000A);
    @(negedge clk); pad_in = '0; pad_in[11] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 other pad ignored", irq_out[4], 0);
    pad_in[10] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 selected pad", irq_out[4], 1);
    chk("R3 neighbour channel", irq_out[5], 0);

    // R4 latency with bypassed filter
    wr(8'h08, 0); wr(8'h04, 32'h0000_0001);
    @(negedge clk); pad_in = '0;
    repeat (10) @(negedge clk);
    pad_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 latency edge 3", irq_out[0], 0);
    @(negedge clk);
    chk("R4 latency edge 4", irq_out[0], 1);

    // R7 filter window 5
    pad_in[1] = 1'b0;
    wr(8'h0C, 32'h0000_0005);
    repeat (12) @(negedge clk);
    chk("R7 settled low", irq_out[0], 0);
    pad_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    pad_in[1] = 1'b0;
    count_rises(0, 15, rises);
    chk("R7 short glitch rejected", rises, 0);
    pad_in[1] = 1'b1;
    repeat (7) @(negedge clk);
    chk("R7 edge N+2", irq_out[0], 0);
    @(negedge clk);
    chk("R7 edge N+3", irq_out[0], 1);
    wr(8'h0C, 0);

    // R8 reconfiguration without false pulses
    @(negedge clk); pad_in = '0; pad_in[21] = 1'b1;
    wr(8'h04, 32'h1400_0000);
    wr(8'h00, 32'h0000_0008);
    repeat (12) @(negedge clk);
    wr(8'h04, 32'h1500_0000);
    count_rises(3, 12, rises);
    chk("R8 selector change", rises, 0);
    wr(8'h00, 32'h0008_0008);
    repeat (12) @(negedge clk);
    wr(8'h00, 32'h0000_0008);
    count_rises(3, 12, rises);
    chk("R8 mode change", rises, 0);
    pad_in[21] = 1'b0;
    repeat (8) @(negedge clk);
    pad_in[21] = 1'b1;
    count_rises(3, 10, rises);
    chk("R8 real edge after change", rises, 1);

    // R9 independence
    wr(8'h00, 0);
    wr(8'h08, 32'h001F_1E00);
    @(negedge clk); pad_in = '0; pad_in[30] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 ch5 driven", irq_out[5], 1);
    chk("R9 ch6 untouched", irq_out[6], 0);
    chk("R9 ch4 untouched", irq_out[4], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule